// File: doc/BRIEF.md
# Vertical Blanking Line Timer

This block sits behind a line-rate recovery stage in a video timing path. It counts horizontal line strobes between vertical sync edges, latches the length of each frame as a 12-bit count, and shapes a vertical blanking window from that count. The window is placed a programmable number of lines before and after the vertical edge. The block also keeps an odd/even field flag and a lock indicator. The lock indicator is built from a per-line "good line" qualifier that an upstream sync separator supplies.

All inputs are synchronous to one system clock. The line strobe and the vertical edge are single-cycle pulses. Every output is a register that changes on the same clock edge that samples the pulse causing the change. The blanking window length, the field-flag timing mode and the blanking enable are configuration inputs that are expected to stay stable across a frame.

Top module: `vblank_line_timer`

## Requirements
- R1: On each `vsync_edge` pulse, the number of `line_stb` pulses seen since the previous vertical edge is captured. It appears as `{lpf_hi, lpf_lo}`, with `lpf_hi` holding bits 11:8 and `lpf_lo` holding bits 7:0. The captured value changes at no other time.
- R2: If no vertical edge arrives, the running line count stops at 4095. A later capture then reports 4095.
- R3: `lpf_updated` goes high on the edge that captures a count and goes low on the edge that samples a `count_rd` pulse. When a capture and a read fall in the same cycle, the flag ends high.
- R4: After a vertical edge, `vblank` is high from that edge until the `lines_after`-th following line strobe, and low again from that strobe on. A value of 0 gives no blanking after the edge.
- R5: Before the edge, `vblank` is high once the line count since the previous edge reaches (captured count − `lines_before`). The captured count used here is the one from the previous frame. When that count is zero, or `lines_before` is 0, no blanking is produced before the edge.
- R6: While `blank_en` is low, `vblank` stays low.
- R7: `sync_lock` rises on the third consecutive line strobe that has `good_line` high. A strobe with `good_line` low restarts that run.
- R8: Once locked, `sync_lock` falls only on the 21st consecutive strobe with `good_line` low. Any good line restarts the miss run.
- R9: `odd_even` is high for an odd field and low for an even field, taken from `field_hint` as sampled at the vertical edge. With `field_rise_mode` high, the flag changes on the vertical edge itself. With it low, the flag changes on the first line strobe after that edge.
- R10: During and right after reset, `vblank`, `odd_even`, `sync_lock`, `lpf_updated` and the count outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_stb | input | 1 | One-cycle pulse per horizontal line |
| vsync_edge | input | 1 | One-cycle pulse at the vertical sync leading edge |
| good_line | input | 1 | Qualifier for the current line, sampled with `line_stb` |
| field_hint | input | 1 | Field parity (1 = odd), sampled at `vsync_edge` |
| field_rise_mode | input | 1 | 1: field flag changes on the vertical edge; 0: on the next line |
| blank_en | input | 1 | Enables blanking generation |
| lines_before | input | 4 | Blanking lines before the vertical edge |
| lines_after | input | 7 | Blanking lines after the vertical edge |
| count_rd | input | 1 | Read pulse that clears `lpf_updated` |
| vblank | output | 1 | Vertical blanking window |
| odd_even | output | 1 | Field flag, high for odd field |
| sync_lock | output | 1 | Line-qualification lock indicator |
| lpf_hi | output | 4 | Captured lines-per-frame, bits 11:8 |
| lpf_lo | output | 8 | Captured lines-per-frame, bits 7:0 |
| lpf_updated | output | 1 | New count captured since the last read |

## Verification
The assertions assume that `line_stb` and `vsync_edge` are single-cycle pulses that never fall in the same cycle. They also assume that `good_line` is meaningful only while `line_stb` is high. The bench respects this by driving each pulse for exactly one clock from a task, never driving both in one call, and changing the configuration inputs only between frames, right before a vertical edge. The bench also keeps `lines_before` below the frame length of every table vector. This keeps the window before the edge from wrapping into the start of the frame.

// File: rtl/vbt_pkg.sv
// Package: shared widths and defaults for the vertical blanking line timer.
// Assumes a 12-bit lines-per-frame count split into a nibble and a byte.
package vbt_pkg;
    localparam int LPF_W       = 12;
    localparam int LPF_HI_W    = 4;
    localparam int LPF_LO_W    = LPF_W - LPF_HI_W;
    localparam int AFT_W_DEF   = 7;
    localparam int BEF_W_DEF   = 4;
    localparam int GOOD_DEF    = 3;
    localparam int MISS_DEF    = 20;

    typedef logic [LPF_W-1:0] lpf_t;
endpackage

// File: rtl/vbt_frame_counter.sv
// Module: counts line strobes since the last vertical edge, saturating at
// the all-ones value, and captures the count at each vertical edge.
// Assumes line_stb and vsync_edge are single-cycle pulses. It exposes its
// next-state values so a neighbour can register outputs on the same edge.
module vbt_frame_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_stb,
    input  logic             vsync_edge,
    input  logic             count_rd,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic [CNT_W-1:0] cap_nxt,
    output logic [CNT_W-1:0] cap_q,
    output logic             updated
);
    localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

    logic [CNT_W-1:0] line_cnt;

    // next running count and next captured count
    always_comb begin
        cnt_nxt = line_cnt;
        cap_nxt = cap_q;
        if (vsync_edge) begin
            cnt_nxt = CNT_W'(line_stb);
            cap_nxt = line_cnt;
        end else if (line_stb && line_cnt != MAXC) begin
            cnt_nxt = line_cnt + CNT_W'(1);
        end
    end

    // register running and captured counts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt <= '0;
            cap_q    <= '0;
        end else begin
            line_cnt <= cnt_nxt;
            cap_q    <= cap_nxt;
        end
    end

    // update flag: capture sets, read clears, capture wins
    always_ff @(posedge clk) begin
        if (!rst_n)          updated <= 1'b0;
        else if (vsync_edge) updated <= 1'b1;
        else if (count_rd)   updated <= 1'b0;
    end

    // R3
    upd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(updated) |-> $past(vsync_edge));

    // R1
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_edge |=> $stable(cap_q));
endmodule

// File: rtl/vbt_blank_gen.sv
// Module: shapes the vertical blanking window. The part after the edge is
// a down-counter loaded at the edge. The part before the edge compares the
// running count with the previous frame's captured length.
// Assumes the count inputs are the counter's next-state values.
module vbt_blank_gen #(
    parameter int CNT_W = 12,
    parameter int AFT_W = 7,
    parameter int BEF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_stb,
    input  logic             vsync_edge,
    input  logic             blank_en,
    input  logic [BEF_W-1:0] lines_before,
    input  logic [AFT_W-1:0] lines_after,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] cap_nxt,
    output logic             vblank
);
    localparam int SUM_W = CNT_W + 1;

    logic [AFT_W-1:0] post_left;
    logic [AFT_W-1:0] post_nxt;
    logic [SUM_W-1:0] reach;
    logic             pre_hit;

    // next value of the lines-after-edge countdown
    always_comb begin
        post_nxt = post_left;
        if (vsync_edge)                       post_nxt = lines_after;
        else if (line_stb && post_left != '0) post_nxt = post_left - AFT_W'(1);
    end

    // pre-edge window test against the previous frame's length
    always_comb begin
        reach   = SUM_W'(cnt_nxt) + SUM_W'(lines_before);
        pre_hit = (cap_nxt != '0) && (lines_before != '0) &&
                  (reach >= SUM_W'(cap_nxt));
    end

    // register countdown and blanking output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            post_left <= '0;
            vblank    <= 1'b0;
        end else begin
            post_left <= post_nxt;
            vblank    <= blank_en && ((post_nxt != '0) || pre_hit);
        end
    end

    // R6
    blank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_en |=> !vblank);
endmodule

// File: rtl/vbt_lock_tracker.sv
// Module: lock indicator built from per-line qualification. It asserts
// after GOOD_LINES consecutive good lines and drops on the line that makes
// more than MISS_LIMIT consecutive missing lines.
// Assumes good_line is only meaningful while line_stb is high.
module vbt_lock_tracker #(
    parameter int GOOD_LINES = 3,
    parameter int MISS_LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_stb,
    input  logic good_line,
    output logic locked
);
    localparam int GW = $clog2(GOOD_LINES + 1);
    localparam int MW = $clog2(MISS_LIMIT + 2);

    logic [GW-1:0] good_run;
    logic [MW-1:0] miss_run;

    // track consecutive good and missing lines and update lock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_run <= '0;
            miss_run <= '0;
            locked   <= 1'b0;
        end else if (line_stb) begin
            if (good_line) begin
                miss_run <= '0;
                if (good_run != GW'(GOOD_LINES)) good_run <= good_run + GW'(1);
                if (good_run == GW'(GOOD_LINES - 1)) locked <= 1'b1;
            end else begin
                good_run <= '0;
                if (miss_run != MW'(MISS_LIMIT)) miss_run <= miss_run + MW'(1);
                else                             locked   <= 1'b0;
            end
        end
    end

    // R7
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(line_stb && good_line));

    // R8
    lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(line_stb && !good_line));
endmodule

// File: rtl/vbt_field_flag.sv
// Module: odd/even field flag. The field parity is sampled at the vertical
// edge and applied either at once or on the next line strobe.
// Assumes field_hint is valid in the cycle of vsync_edge.
module vbt_field_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic line_stb,
    input  logic vsync_edge,
    input  logic field_hint,
    input  logic rise_mode,
    output logic odd_even
);
    logic pend_val;
    logic pend_v;

    // hold or apply the field parity sampled at the vertical edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_even <= 1'b0;
            pend_val <= 1'b0;
            pend_v   <= 1'b0;
        end else if (vsync_edge) begin
            if (rise_mode) begin
                odd_even <= field_hint;
                pend_v   <= 1'b0;
            end else begin
                pend_val <= field_hint;
                pend_v   <= 1'b1;
            end
        end else if (line_stb && pend_v) begin
            odd_even <= pend_val;
            pend_v   <= 1'b0;
        end
    end

    // R9
    field_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(odd_even) |-> $past(vsync_edge || line_stb));
endmodule

// File: rtl/vblank_line_timer.sv
// Module: top of the vertical blanking line timer. It joins the frame
// counter, the blanking generator, the lock tracker and the field flag.
// Assumes one clock domain and single-cycle line and vertical pulses.
module vblank_line_timer
    import vbt_pkg::*;
#(
    parameter int AFT_W      = AFT_W_DEF,
    parameter int BEF_W      = BEF_W_DEF,
    parameter int GOOD_LINES = GOOD_DEF,
    parameter int MISS_LIMIT = MISS_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_stb,
    input  logic                vsync_edge,
    input  logic                good_line,
    input  logic                field_hint,
    input  logic                field_rise_mode,
    input  logic                blank_en,
    input  logic [BEF_W-1:0]    lines_before,
    input  logic [AFT_W-1:0]    lines_after,
    input  logic                count_rd,
    output logic                vblank,
    output logic                odd_even,
    output logic                sync_lock,
    output logic [LPF_HI_W-1:0] lpf_hi,
    output logic [LPF_LO_W-1:0] lpf_lo,
    output logic                lpf_updated
);
    lpf_t cnt_nxt;
    lpf_t cap_nxt;
    lpf_t cap_q;

    vbt_frame_counter #(.CNT_W(LPF_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_stb   (line_stb),
        .vsync_edge (vsync_edge),
        .count_rd   (count_rd),
        .cnt_nxt    (cnt_nxt),
        .cap_nxt    (cap_nxt),
        .cap_q      (cap_q),
        .updated    (lpf_updated)
    );

    vbt_blank_gen #(.CNT_W(LPF_W), .AFT_W(AFT_W), .BEF_W(BEF_W)) u_blank (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_stb     (line_stb),
        .vsync_edge   (vsync_edge),
        .blank_en     (blank_en),
        .lines_before (lines_before),
        .lines_after  (lines_after),
        .cnt_nxt      (cnt_nxt),
        .cap_nxt      (cap_nxt),
        .vblank       (vblank)
    );

    vbt_lock_tracker #(.GOOD_LINES(GOOD_LINES), .MISS_LIMIT(MISS_LIMIT)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_stb  (line_stb),
        .good_line (good_line),
        .locked    (sync_lock)
    );

    vbt_field_flag u_field (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_stb   (line_stb),
        .vsync_edge (vsync_edge),
        .field_hint (field_hint),
        .rise_mode  (field_rise_mode),
        .odd_even   (odd_even)
    );

    // split the captured count into its two published fields
    always_comb begin
        lpf_hi = cap_q[LPF_W-1:LPF_LO_W];
        lpf_lo = cap_q[LPF_LO_W-1:0];
    end
endmodule

// File: tb/tb_vblank_line_timer.sv
// Bench: table-driven frames, then directed tests of lock, field flag,
// update flag and count saturation. It uses a requirement-level model.
module tb_vblank_line_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_stb = 1'b0, vsync_edge = 1'b0, good_line = 1'b0;
    logic       field_hint = 1'b0, field_rise_mode = 1'b1, blank_en = 1'b1;
    logic [3:0] lines_before = 4'd4;
    logic [6:0] lines_after = 7'd0;
    logic       count_rd = 1'b0;
    logic       vblank, odd_even, sync_lock, lpf_updated;
    logic [3:0] lpf_hi;
    logic [7:0] lpf_lo;

    int checks = 0, fails = 0;
    int m_cnt = 0, m_cap = 0, m_post = 0;

    always #2 clk = ~clk;

    vblank_line_timer dut (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .vsync_edge(vsync_edge),
        .good_line(good_line), .field_hint(field_hint),
        .field_rise_mode(field_rise_mode), .blank_en(blank_en),
        .lines_before(lines_before), .lines_after(lines_after),
        .count_rd(count_rd), .vblank(vblank), .odd_even(odd_even),
        .sync_lock(sync_lock), .lpf_hi(lpf_hi), .lpf_lo(lpf_lo),
        .lpf_updated(lpf_updated)
    );

    // frames: lines, lines_before, lines_after, blank_en
    localparam int VEC [5][4] = '{
        '{30, 4, 16, 1}, '{12, 3, 5, 1}, '{40, 0, 0, 1},
        '{25, 6, 10, 0}, '{20, 15, 3, 1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_vb();
        int pre = (m_cap != 0 && lines_before != 0 &&
                   m_cnt + int'(lines_before) >= m_cap) ? 1 : 0;
        return (blank_en && (m_post > 0 || pre == 1)) ? 1 : 0;
    endfunction

    task automatic line(input bit g);
        @(negedge clk); line_stb = 1'b1; good_line = g;
        @(negedge clk); line_stb = 1'b0;
        if (m_cnt < 4095) m_cnt++;
        if (m_post > 0) m_post--;
    endtask

    task automatic vedge();
        @(negedge clk); vsync_edge = 1'b1;
        @(negedge clk); vsync_edge = 1'b0;
        m_cap = m_cnt; m_cnt = 0; m_post = int'(lines_after);
    endtask

    task automatic rd();
        @(negedge clk); count_rd = 1'b1;
        @(negedge clk); count_rd = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 vblank", vblank, 0);
        chk("R10 lock", sync_lock, 0);
        chk("R10 field", odd_even, 0);
        chk("R10 updated", lpf_updated, 0);
        chk("R10 count", {lpf_hi, lpf_lo}, 0);
        rst_n = 1'b1;

        // R7 / R8 lock; R5 no pre-blanking while captured count is zero
        line(1); line(1);
        chk("R7 two good", sync_lock, 0);
        line(1);
        chk("R7 third good", sync_lock, 1);
        chk("R5 zero count", vblank, 0);
        for (int i = 0; i < 20; i++) line(0);
        chk("R8 twenty missing", sync_lock, 1);
        line(1);
        for (int i = 0; i < 20; i++) line(0);
        chk("R8 miss run restarted", sync_lock, 1);
        line(0);
        chk("R8 21st missing", sync_lock, 0);
        chk("R5 zero count", vblank, 0);
        line(1); line(1); line(0); line(1); line(1);
        chk("R7 broken run", sync_lock, 0);
        line(1);
        chk("R7 relock", sync_lock, 1);

        // table of frames: R1 R3 R4 R5 R6
        for (int v = 0; v < 5; v++) begin
            string tag;
            lines_before = 4'(VEC[v][1]);
            lines_after  = 7'(VEC[v][2]);
            blank_en     = VEC[v][3] != 0;
            tag = blank_en ? "R4 R5 vblank" : "R6 vblank";
            vedge();
            chk("R1 count", {lpf_hi, lpf_lo}, m_cap);
            chk("R3 set", lpf_updated, 1);
            chk(tag, vblank, exp_vb());
            rd();
            chk("R3 cleared", lpf_updated, 0);
            for (int f = 0; f < 2; f++) begin
                for (int k = 0; k < VEC[v][0]; k++) begin
                    line(1);
                    chk(tag, vblank, exp_vb());
                end
                vedge();
                chk("R1 count", {lpf_hi, lpf_lo}, VEC[v][0]);
                chk(tag, vblank, exp_vb());
                chk("R3 set", lpf_updated, 1);
                rd();
                chk("R3 cleared", lpf_updated, 0);
            end
        end

        // R3 capture and read in the same cycle
        @(negedge clk); vsync_edge = 1'b1; count_rd = 1'b1;
        @(negedge clk); vsync_edge = 1'b0; count_rd = 1'b0;
        m_cap = m_cnt; m_cnt = 0; m_post = int'(lines_after);
        chk("R3 capture wins", lpf_updated, 1);
        rd();
        chk("R3 read", lpf_updated, 0);

        // R9 field flag
        field_rise_mode = 1'b1; field_hint = 1'b1;
        vedge();
        chk("R9 rise mode odd", odd_even, 1);
        field_rise_mode = 1'b0; field_hint = 1'b0;
        vedge();
        chk("R9 deferred hold", odd_even, 1);
        field_hint = 1'b1;
        line(1);
        chk("R9 deferred apply", odd_even, 0);
        line(1);
        chk("R9 steady", odd_even, 0);

        // R2 saturation
        blank_en = 1'b0;
        vedge();
        for (int i = 0; i < 4100; i++) line(1);
        vedge();
        chk("R2 saturated", {lpf_hi, lpf_lo}, 4095);
        chk("R1 high nibble", lpf_hi, 15);
        chk("R1 low byte", lpf_lo, 255);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule